// File: doc/BRIEF.md
# Page Program Buffer and Commit Engine

This block sits behind the serial front end of a flash-style memory. Once a program instruction has been decoded, it gathers the data bytes that follow into a page-sized buffer. The start offset may be anywhere in the page. Bytes that run past the last offset fold back to offset zero of the same page, and any byte beyond a full page replaces the one already buffered at that offset. The buffer is kept together with a per-offset record of which locations were actually supplied.

When chip select is released cleanly on a byte boundary, and the write-enable latch was set when the command began, the engine commits the buffered bytes to a byte-wide memory port. Each location is committed by a read followed by a write of the old value ANDed with the new one, so a bit can only go from 1 to 0. A neighbouring protection decoder judges every address the engine drives; locked addresses are skipped. Busy is held for a fixed number of clock cycles per committed byte. In its final cycle the engine pulses a request to clear the write-enable latch.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, `busy`, `wel_clr`, `mem_rd_en` and `mem_wr_en` are all low, and they stay low until a program cycle is launched.
- R2: Byte k of a command (counting from 0) is stored at page offset (start offset + k) mod PAGE_BYTES, inside the page given by the command address; data never spills into the next page.
- R3: When more than PAGE_BYTES bytes are supplied, the byte committed at each offset is the last one supplied for that offset.
- R4: Offsets of the page that received no byte keep their previous memory contents.
- R5: A committed location holds (previous value AND supplied byte); no bit ever goes from 0 to 1.
- R6: A release (`sel_end`) with `partial_bits` high abandons the command: there is no busy period, no memory access and no `wel_clr`.
- R7: A command whose `wel_in` is low at `cmd_start` is ignored in full: there is no busy period, no memory write and no `wel_clr`.
- R8: After a qualifying release, `busy` rises in the next cycle and stays high for exactly min(N, PAGE_BYTES) × BYTE_TICKS cycles, where N is the number of bytes supplied.
- R9: `wel_clr` is a single-cycle pulse in the last busy cycle of every launched program cycle, including one in which every address is locked.
- R10: No write is issued to an address for which `lock_hit` is high; the other addresses of the same command are still committed.
- R11: While `busy` is high, `cmd_start`, data bytes and releases are ignored and leave memory unchanged.
- R12: A clean release after zero data bytes launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: a program instruction and its address have been decoded |
| cmd_addr | input | ADDR_W | Start byte address (page index above page offset) |
| wel_in | input | 1 | Write-enable latch state, sampled with `cmd_start` |
| byte_valid | input | 1 | Pulse: one complete data byte is on `byte_data` |
| byte_data | input | 8 | Data byte |
| sel_end | input | 1 | Pulse: chip select has been released |
| partial_bits | input | 1 | With `sel_end`: high if bits of an unfinished byte had been shifted in |
| lock_hit | input | 1 | Protection verdict for the current `mem_addr` (1 = locked) |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
The bench builds the engine with an 8-byte page, four pages and three cycles per byte. This makes the wrap, a run of more than a page (11 bytes folding over 8 offsets) and a page whose upper half is locked reachable in a few hundred cycles, while every page still fits in a 32-byte memory model kept in the bench. The small tick count keeps each busy window short enough to compare on every clock. It is still long enough to inject a complete second command inside a busy period.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    typedef enum logic {
        GATHER_IDLE = 1'b0,
        GATHER_OPEN = 1'b1
    } gather_state_t;

    // Smallest r with 2**r >= v.
    function automatic int ceil_log2(input int v);
        int r;
        for (r = 0; (1 << r) < v; r++) begin
        end
        return r;
    endfunction

    // Flash programming can only pull bits low.
    function automatic logic [7:0] program_merge(input logic [7:0] old_b,
                                                 input logic [7:0] new_b);
        return old_b & new_b;
    endfunction

endpackage

// File: rtl/ppe_buffer.sv
module ppe_buffer #(
    parameter int PAGE_BYTES = 256,
    parameter int OFF_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data,
    output logic             rd_written
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_off] <= wr_data;
        end
    end

    assign rd_data    = data_q[rd_off];
    assign rd_written = mask_q[rd_off];
endmodule

// File: rtl/ppe_sequencer.sv
module ppe_sequencer #(
    parameter int BYTE_TICKS = 7500,
    parameter int OFF_W      = 8,
    parameter int CNT_W      = 9,
    parameter int TICK_W     = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [OFF_W-1:0] launch_off,
    input  logic [CNT_W-1:0] launch_cnt,
    output logic             busy,
    output logic [OFF_W-1:0] walk_off,
    output logic             rd_phase,
    output logic             wr_phase,
    output logic             last_slot
);
    logic              busy_q;
    logic [OFF_W-1:0]  walk_q;
    logic [CNT_W-1:0]  left_q;
    logic [TICK_W-1:0] tick_q;
    logic              slot_end;

    assign slot_end = (tick_q == TICK_W'(BYTE_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            walk_q <= '0;
            left_q <= '0;
            tick_q <= '0;
        end else if (!busy_q) begin
            if (launch) begin
                busy_q <= 1'b1;
                walk_q <= launch_off;
                left_q <= launch_cnt;
                tick_q <= '0;
            end
        end else if (slot_end) begin
            tick_q <= '0;
            walk_q <= walk_q + OFF_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end else begin
            tick_q <= tick_q + TICK_W'(1);
        end
    end

    assign busy      = busy_q;
    assign walk_off  = walk_q;
    assign rd_phase  = busy_q && (tick_q == '0);
    assign wr_phase  = busy_q && (tick_q == TICK_W'(1));
    assign last_slot = busy_q && slot_end && (left_q == CNT_W'(1));
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
    import ppe_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PAGE_COUNT = 2048,
    parameter int BYTE_TICKS = 7500,
    localparam int OFF_W  = ceil_log2(PAGE_BYTES),
    localparam int PAGE_W = ceil_log2(PAGE_COUNT),
    localparam int ADDR_W = OFF_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wel_in,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              sel_end,
    input  logic              partial_bits,
    input  logic              lock_hit,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              wel_clr
);
    localparam int CNT_W  = OFF_W + 1;
    localparam int TICK_W = (BYTE_TICKS > 2) ? ceil_log2(BYTE_TICKS) : 1;

    gather_state_t     gather_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  head_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic              accept, take, launch, cnt_full;

    logic [OFF_W-1:0]  walk_off;
    logic [7:0]        buf_data;
    logic              buf_written, rd_phase, wr_phase, last_slot;

    assign accept   = (gather_q == GATHER_IDLE) && !busy && cmd_start && wel_in;
    assign take     = (gather_q == GATHER_OPEN) && byte_valid;
    assign cnt_full = (cnt_q == CNT_W'(PAGE_BYTES));
    assign cnt_eff  = (take && !cnt_full) ? cnt_q + CNT_W'(1) : cnt_q;
    assign launch   = (gather_q == GATHER_OPEN) && sel_end && !partial_bits
                      && (cnt_eff != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gather_q <= GATHER_IDLE;
            page_q   <= '0;
            head_q   <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
        end else if (gather_q == GATHER_IDLE) begin
            if (accept) begin
                gather_q <= GATHER_OPEN;
                page_q   <= cmd_addr[ADDR_W-1:OFF_W];
                head_q   <= cmd_addr[OFF_W-1:0];
                ptr_q    <= cmd_addr[OFF_W-1:0];
                cnt_q    <= '0;
            end
        end else begin
            if (take) begin
                ptr_q <= ptr_q + OFF_W'(1);
                cnt_q <= cnt_eff;
            end
            if (sel_end) begin
                gather_q <= GATHER_IDLE;
            end
        end
    end

    ppe_buffer #(
        .PAGE_BYTES(PAGE_BYTES),
        .OFF_W     (OFF_W)
    ) u_buffer (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .wr_en     (take),
        .wr_off    (ptr_q),
        .wr_data   (byte_data),
        .rd_off    (walk_off),
        .rd_data   (buf_data),
        .rd_written(buf_written)
    );

    ppe_sequencer #(
        .BYTE_TICKS(BYTE_TICKS),
        .OFF_W     (OFF_W),
        .CNT_W     (CNT_W),
        .TICK_W    (TICK_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .launch_off(head_q),
        .launch_cnt(cnt_eff),
        .busy      (busy),
        .walk_off  (walk_off),
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .last_slot (last_slot)
    );

    assign mem_addr  = {page_q, walk_off};
    assign mem_rd_en = rd_phase;
    assign mem_wr_en = wr_phase && buf_written && !lock_hit;
    assign mem_wdata = program_merge(mem_rdata, buf_data);
    assign wel_clr   = last_slot;
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_end,
    input logic       partial_bits,
    input logic       lock_hit,
    input logic [7:0] mem_rdata,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] mem_wdata,
    input logic       busy,
    input logic       wel_clr
);
    // R10
    locked_skip_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !lock_hit);

    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> ((mem_wdata & ~mem_rdata) == 8'h00));

    // R8
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sel_end));

    // R9
    clr_inside_chk: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> busy);

    // R9
    clr_final_chk: assert property (@(posedge clk) disable iff (rst)
        wel_clr |=> !busy);

    // R6
    partial_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sel_end && partial_bits) |=> !busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr_en && !mem_rd_en && !wel_clr));
endmodule

bind page_prog_engine ppe_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_end     (sel_end),
    .partial_bits(partial_bits),
    .lock_hit    (lock_hit),
    .mem_rdata   (mem_rdata),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .wel_clr     (wel_clr)
);

// File: tb/page_prog_engine_test.sv
`timescale 1ns/1ps
module page_prog_engine_test;
    localparam int P  = 8;
    localparam int PC = 4;
    localparam int T  = 3;
    localparam int AW = 5;
    localparam int MEMSZ = P * PC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          wel_in = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          sel_end = 1'b0;
    logic          partial_bits = 1'b0;
    logic          lock_hit;
    logic [7:0]    mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_wr_en, busy, wel_clr;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;
    int lock_base = MEMSZ;
    int exp_left = 0;
    int pend_n = 0;
    bit pend_go = 1'b0;
    bit cmp_on = 1'b0;
    bit init_req = 1'b0;
    logic [7:0] mem [MEMSZ];
    logic [7:0] exp_mem [MEMSZ];

    always #2 clk = ~clk;

    page_prog_engine #(.PAGE_BYTES(P), .PAGE_COUNT(PC), .BYTE_TICKS(T)) uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .wel_in(wel_in), .byte_valid(byte_valid), .byte_data(byte_data),
        .sel_end(sel_end), .partial_bits(partial_bits), .lock_hit(lock_hit),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .busy(busy),
        .wel_clr(wel_clr));

    function automatic logic [7:0] init_val(input int i);
        if (i == 14) return 8'h0F;
        if (i == 20) return 8'h3C;
        return 8'hFF;
    endfunction

    assign lock_hit = (int'(mem_addr) >= lock_base);

    // Array model behind the memory port: one-cycle read latency.
    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] <= init_val(i);
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr];
            if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        end
    end

    // Reference timing: remaining busy cycles.
    always @(posedge clk) begin
        if (rst) exp_left <= 0;
        else if (exp_left > 0) exp_left <= exp_left - 1;
        else if (sel_end && pend_go) exp_left <= pend_n * T;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(busy == (exp_left > 0), "R8 busy window", int'(busy), int'(exp_left > 0));
            check(wel_clr == (exp_left == 1), "R9 wel_clr pulse", int'(wel_clr), int'(exp_left == 1));
            if (exp_left == 0)
                check(!mem_wr_en && !mem_rd_en, "R1 no access when idle",
                      int'(mem_wr_en | mem_rd_en), 0);
        end
    end

    task automatic run_cmd(input int addr, input bit wel, input int n,
                           input int seed, input bit partial, input bit model_it);
        logic [7:0] pbuf [P];
        bit         wr [P];
        int         start = addr % P;
        int         page  = addr / P;
        bit         go;
        for (int i = 0; i < P; i++) begin pbuf[i] = 8'h00; wr[i] = 1'b0; end
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = AW'(addr); wel_in = wel;
        @(negedge clk);
        cmd_start = 1'b0; wel_in = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_data  = 8'((seed * 7 + i * 29 + 3) & 8'hFF);
            byte_valid = 1'b1;
            pbuf[(start + i) % P] = byte_data;
            wr[(start + i) % P] = 1'b1;
            @(negedge clk);
            byte_valid = 1'b0;
        end
        go = model_it && wel && (n > 0) && !partial;
        pend_n = (n < P) ? n : P;
        pend_go = go;
        sel_end = 1'b1; partial_bits = partial;
        @(negedge clk);
        sel_end = 1'b0; partial_bits = 1'b0; pend_go = 1'b0;
        if (go) begin
            for (int o = 0; o < P; o++) begin
                int a = page * P + o;
                if (wr[o] && a < lock_base) exp_mem[a] = exp_mem[a] & pbuf[o];
            end
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_left != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_mem(input string tag);
        for (int i = 0; i < MEMSZ; i++)
            check(mem[i] === exp_mem[i], tag, int'(mem[i]), int'(exp_mem[i]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) exp_mem[i] = init_val(i);
        init_req = 1'b1;
        repeat (3) @(negedge clk);
        init_req = 1'b0;
        // R1: reset state
        check(!busy && !wel_clr && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
              int'({busy, wel_clr, mem_rd_en, mem_wr_en}), 0);
        rst = 1'b0;
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5: page 1 from offset 5, five bytes wrap onto offsets 0,1
        run_cmd(13, 1'b1, 5, 1, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R2 R4 R5 wrap and merge");

        // R3: 11 bytes into page 2 from offset 2, later bytes win
        run_cmd(18, 1'b1, 11, 4, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R3 overwrite past page");

        // R6: release in the middle of a byte
        run_cmd(0, 1'b1, 3, 9, 1'b1, 1'b1);
        wait_idle();
        compare_mem("R6 partial release");

        // R7: write-enable latch clear at command start
        run_cmd(2, 1'b0, 4, 11, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R7 latch not set");

        // R12: clean release with no data
        run_cmd(3, 1'b1, 0, 12, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R12 zero bytes");

        // R10 R9: upper half of page 3 locked
        lock_base = 28;
        run_cmd(26, 1'b1, 4, 15, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R10 partial lock");

        // R9: every address locked, latch clear still pulses
        lock_base = 24;
        run_cmd(25, 1'b1, 3, 17, 1'b0, 1'b1);
        wait_idle();
        compare_mem("R9 R10 fully locked");
        lock_base = MEMSZ;

        // R11: a whole command injected while busy
        run_cmd(0, 1'b1, 2, 21, 1'b0, 1'b1);
        check(busy == 1'b1, "R11 busy before injection", int'(busy), 1);
        run_cmd(4, 1'b1, 1, 23, 1'b0, 1'b0);
        wait_idle();
        compare_mem("R11 ignored while busy");

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule